// File: doc/BRIEF.md
# Directory Coherence Controller

This block is the home node of a small shared-memory multiprocessor. For every memory block it keeps a directory entry: a coherence state (Uncached, Shared or Exclusive), a presence vector with one bit per cache, and the identity of the owning cache. Caches send it read misses, write misses and write backs, one message at a time, through a valid/ready request port. It answers each miss with a data reply. It sends invalidates only to the caches whose presence bit is set, and it sends a fetch request to the owner when the block is dirty somewhere. The backing memory is outside the block. The controller reads it combinationally and writes it on a clock edge.

The controller is a five-state machine. **IDLE** accepts any message and looks up the entry. The transition *IDLE→REPLY* handles misses that memory can serve at once. *IDLE→INVAL* handles a write miss to a Shared block that has other sharers. *IDLE→FETCH* handles any miss to an Exclusive block. *IDLE→IDLE* handles write backs. **INVAL** sends one invalidate per cycle and moves *INVAL→REPLY* when no targets are left. **FETCH** pulses the fetch request and moves *FETCH→AWAIT*. **AWAIT** stalls the request port until the owner's write back arrives, then moves *AWAIT→REPLY*. **REPLY** drives the data reply for one cycle and returns *REPLY→IDLE*.

Top module: `dir_ctrl`

## Requirements
- R1: After reset every block is Uncached with an empty presence vector, all message outputs are low and `req_ready` is high.
- R2: A read miss (`req_kind` 0) to an Uncached or Shared block produces a reply in the cycle after acceptance. The reply goes to the requester and carries the memory contents. The requester is added to the sharers and the block becomes Shared.
- R3: A write miss (`req_kind` 1) to an Uncached block produces a reply in the cycle after acceptance carrying the memory contents. The block becomes Exclusive with the requester as its only sharer and owner.
- R4: A write miss to a Shared block sends one invalidate per cycle, starting in the cycle after acceptance. Targets are every sharer except the requester, in ascending cache index. The reply follows in the cycle after the last invalidate, or in the cycle after acceptance if there is no target. The block then becomes Exclusive, owned by the requester alone.
- R5: A read miss to an Exclusive block pulses a fetch to the owner, naming the block, in the cycle after acceptance. Once the owner's write back is accepted, memory holds its data and the reply in the next cycle carries that data. The block becomes Shared, with the old owner and the requester as sharers.
- R6: A write miss to an Exclusive block performs the same fetch and write back. After the reply the block is Exclusive, owned by the requester alone.
- R7: A write back (`req_kind` 2) from the owner of an Exclusive block writes its data to memory and leaves the block Uncached with no sharers. No reply, invalidate or fetch is produced.
- R8: A write back from a cache that is not the owner, or to a block that is not Exclusive, changes neither memory nor the directory and produces no output.
- R9: While waiting for the fetched data, `req_ready` is high only for a write back (`req_kind` 2) from the fetched owner to the fetched block.
- R10: Messages are handled one at a time. `req_ready` is high in the idle state and low from the acceptance of a miss until its reply has been driven, except for the matching write back of R9.
- R11: At most one of reply, invalidate and fetch is valid in any cycle, and the fetch request lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write back, 3 no operation |
| req_src | input | IDW | Sending cache index |
| req_blk | input | BW | Block number |
| req_data | input | DATA_W | Write-back data |
| rep_valid | output | 1 | Data reply valid |
| rep_dst | output | IDW | Reply destination cache |
| rep_data | output | DATA_W | Reply block data |
| inv_valid | output | 1 | Invalidate valid |
| inv_dst | output | IDW | Invalidate target cache |
| inv_blk | output | BW | Invalidated block |
| fetch_valid | output | 1 | Fetch request valid |
| fetch_dst | output | IDW | Owner asked to return the block |
| fetch_blk | output | BW | Fetched block |
| mem_addr | output | BW | Memory block address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data for mem_addr |

## Verification
The bench targets the following corner cases.
- A write miss by a cache that already holds a shared copy. A design that forgot to mask the requester's bit would invalidate the writer itself.
- A write miss where the requester is the only sharer. A design that mishandled the empty scan would stall or emit a spurious invalidate.
- Invalidate ordering across several sharers. The bench checks target and cycle together, so a wrong scan direction is caught.
- While a fetch is outstanding, the bench offers a read miss, a write back from the wrong cache and a write back to the wrong block. A controller that accepted any of them would lose the dirty data.
- Write backs from non-owners and to Shared blocks. The next miss would show a corrupted memory value, or a missing fetch, if either had been taken.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        MSG_RD_MISS = 2'd0,
        MSG_WR_MISS = 2'd1,
        MSG_WRBACK  = 2'd2,
        MSG_NONE    = 2'd3
    } msg_kind_e;

    typedef enum logic [1:0] {
        BLK_UNCACHED = 2'd0,
        BLK_SHARED   = 2'd1,
        BLK_EXCL     = 2'd2
    } blk_state_e;

endpackage

// File: rtl/dir_table.sv
module dir_table
    import dir_pkg::*;
#(
    parameter int NUM_CACHES = 4,
    parameter int NUM_BLOCKS = 8,
    parameter int IDW = 2,
    parameter int BW = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BW-1:0]         rd_blk,
    output blk_state_e            rd_state,
    output logic [NUM_CACHES-1:0] rd_pres,
    output logic [IDW-1:0]        rd_owner,
    input  logic                  wr_en,
    input  logic [BW-1:0]         wr_blk,
    input  blk_state_e            wr_state,
    input  logic [NUM_CACHES-1:0] wr_pres,
    input  logic [IDW-1:0]        wr_owner
);

    blk_state_e            st_q   [NUM_BLOCKS];
    logic [NUM_CACHES-1:0] pres_q [NUM_BLOCKS];
    logic [IDW-1:0]        own_q  [NUM_BLOCKS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BLOCKS; i++) begin
                st_q[i]   <= BLK_UNCACHED;
                pres_q[i] <= '0;
                own_q[i]  <= '0;
            end
        end else if (wr_en) begin
            st_q[wr_blk]   <= wr_state;
            pres_q[wr_blk] <= wr_pres;
            own_q[wr_blk]  <= wr_owner;
        end
    end

    assign rd_state = st_q[rd_blk];
    assign rd_pres  = pres_q[rd_blk];
    assign rd_owner = own_q[rd_blk];

    // An exclusive entry names exactly one sharer, and that sharer is the owner
    assert_excl_sole_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_state == BLK_EXCL) |-> ($countones(wr_pres) == 1 && wr_pres[wr_owner]));

    // Returning a block to Uncached empties its presence vector
    assert_uncached_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_state == BLK_UNCACHED) |-> (wr_pres == '0));

    // Stored exclusive entries keep a single presence bit
    assert_stored_excl_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == BLK_EXCL) |-> $onehot(rd_pres));

endmodule

// File: rtl/inv_pick.sv
module inv_pick #(
    parameter int NUM_CACHES = 4,
    parameter int IDW = 2
) (
    input  logic [NUM_CACHES-1:0] vec,
    output logic [IDW-1:0]        idx
);

    // lowest set bit wins so invalidates leave in ascending cache order
    always_comb begin
        idx = '0;
        for (int i = NUM_CACHES - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDW'(i);
        end
    end

endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
    import dir_pkg::*;
#(
    parameter int NUM_CACHES = 4,
    parameter int NUM_BLOCKS = 8,
    parameter int DATA_W = 16,
    localparam int IDW = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1,
    localparam int BW  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [IDW-1:0]    req_src,
    input  logic [BW-1:0]     req_blk,
    input  logic [DATA_W-1:0] req_data,
    output logic              rep_valid,
    output logic [IDW-1:0]    rep_dst,
    output logic [DATA_W-1:0] rep_data,
    output logic              inv_valid,
    output logic [IDW-1:0]    inv_dst,
    output logic [BW-1:0]     inv_blk,
    output logic              fetch_valid,
    output logic [IDW-1:0]    fetch_dst,
    output logic [BW-1:0]     fetch_blk,
    output logic [BW-1:0]     mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam logic [NUM_CACHES-1:0] BIT0 = {{(NUM_CACHES-1){1'b0}}, 1'b1};

    typedef enum logic [2:0] {S_IDLE, S_INVAL, S_FETCH, S_AWAIT, S_REPLY} fsm_e;

    fsm_e                  state_q, state_d;
    msg_kind_e             kind_q, in_kind;
    logic [IDW-1:0]        src_q, owner_q, pick_idx;
    logic [BW-1:0]         blk_q;
    logic [NUM_CACHES-1:0] scan_q, scan_d;
    logic [NUM_CACHES-1:0] req_oh, src_oh, own_oh;
    logic                  wb_match;

    blk_state_e            rd_state, wr_state;
    logic [NUM_CACHES-1:0] rd_pres, wr_pres;
    logic [IDW-1:0]        rd_owner, wr_owner;
    logic                  wr_en;
    logic [BW-1:0]         wr_blk;

    assign in_kind  = msg_kind_e'(req_kind);
    assign req_oh   = BIT0 << req_src;
    assign src_oh   = BIT0 << src_q;
    assign own_oh   = BIT0 << owner_q;
    assign wb_match = (in_kind == MSG_WRBACK) && (req_src == owner_q) && (req_blk == blk_q);

    dir_table #(
        .NUM_CACHES(NUM_CACHES), .NUM_BLOCKS(NUM_BLOCKS), .IDW(IDW), .BW(BW)
    ) i_table (
        .clk(clk), .rst_n(rst_n),
        .rd_blk(req_blk), .rd_state(rd_state), .rd_pres(rd_pres), .rd_owner(rd_owner),
        .wr_en(wr_en), .wr_blk(wr_blk), .wr_state(wr_state), .wr_pres(wr_pres), .wr_owner(wr_owner)
    );

    inv_pick #(.NUM_CACHES(NUM_CACHES), .IDW(IDW)) i_pick (
        .vec(scan_q), .idx(pick_idx)
    );

    // state register and per-message context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            kind_q  <= MSG_NONE;
            src_q   <= '0;
            owner_q <= '0;
            blk_q   <= '0;
            scan_q  <= '0;
        end else begin
            state_q <= state_d;
            scan_q  <= scan_d;
            if (state_q == S_IDLE && req_valid) begin
                kind_q  <= in_kind;
                src_q   <= req_src;
                blk_q   <= req_blk;
                owner_q <= rd_owner;
            end
        end
    end

    // transitions and directory updates
    always_comb begin
        state_d  = state_q;
        scan_d   = scan_q;
        wr_en    = 1'b0;
        wr_blk   = blk_q;
        wr_state = BLK_UNCACHED;
        wr_pres  = '0;
        wr_owner = src_q;
        unique case (state_q)
            S_IDLE: begin
                wr_blk = req_blk;
                if (req_valid) begin
                    case (in_kind)
                        MSG_RD_MISS: begin
                            if (rd_state == BLK_EXCL) begin
                                state_d = S_FETCH;
                            end else begin
                                wr_en    = 1'b1;
                                wr_state = BLK_SHARED;
                                wr_pres  = rd_pres | req_oh;
                                wr_owner = rd_owner;
                                state_d  = S_REPLY;
                            end
                        end
                        MSG_WR_MISS: begin
                            if (rd_state == BLK_EXCL) begin
                                state_d = S_FETCH;
                            end else begin
                                scan_d = (rd_state == BLK_SHARED) ? (rd_pres & ~req_oh) : '0;
                                if (scan_d != '0) begin
                                    state_d = S_INVAL;
                                end else begin
                                    wr_en    = 1'b1;
                                    wr_state = BLK_EXCL;
                                    wr_pres  = req_oh;
                                    wr_owner = req_src;
                                    state_d  = S_REPLY;
                                end
                            end
                        end
                        MSG_WRBACK: begin
                            if (rd_state == BLK_EXCL && rd_owner == req_src) begin
                                wr_en    = 1'b1;
                                wr_state = BLK_UNCACHED;
                                wr_pres  = '0;
                                wr_owner = rd_owner;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            S_INVAL: begin
                scan_d = scan_q & ~(BIT0 << pick_idx);
                if (scan_d == '0) begin
                    wr_en    = 1'b1;
                    wr_state = BLK_EXCL;
                    wr_pres  = src_oh;
                    wr_owner = src_q;
                    state_d  = S_REPLY;
                end
            end
            S_FETCH: state_d = S_AWAIT;
            S_AWAIT: begin
                if (req_valid && wb_match) begin
                    wr_en = 1'b1;
                    if (kind_q == MSG_RD_MISS) begin
                        wr_state = BLK_SHARED;
                        wr_pres  = src_oh | own_oh;
                        wr_owner = owner_q;
                    end else begin
                        wr_state = BLK_EXCL;
                        wr_pres  = src_oh;
                        wr_owner = src_q;
                    end
                    state_d = S_REPLY;
                end
            end
            S_REPLY: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready   = 1'b0;
        rep_valid   = 1'b0;
        inv_valid   = 1'b0;
        fetch_valid = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = req_blk;
        unique case (state_q)
            S_IDLE: begin
                req_ready = 1'b1;
                mem_we    = req_valid && (in_kind == MSG_WRBACK) &&
                            (rd_state == BLK_EXCL) && (rd_owner == req_src);
            end
            S_INVAL: inv_valid = 1'b1;
            S_FETCH: fetch_valid = 1'b1;
            S_AWAIT: begin
                req_ready = wb_match;
                mem_we    = req_valid && wb_match;
            end
            S_REPLY: begin
                rep_valid = 1'b1;
                mem_addr  = blk_q;
            end
            default: ;
        endcase
    end

    assign rep_dst   = src_q;
    assign rep_data  = mem_rdata;
    assign inv_dst   = pick_idx;
    assign inv_blk   = blk_q;
    assign fetch_dst = owner_q;
    assign fetch_blk = blk_q;
    assign mem_wdata = req_data;

    assert_one_msg_out_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rep_valid, inv_valid, fetch_valid}));

    assert_fetch_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> !fetch_valid);

    assert_inv_skips_requester_R4: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_dst != rep_dst));

    assert_await_owner_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> (!req_ready || (req_kind == 2'd2 && req_src == $past(fetch_dst) &&
                                        req_blk == $past(fetch_blk))));

    assert_reply_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |=> !rep_valid);

endmodule

// File: tb/test_dir_ctrl.sv
`timescale 1ns/100ps
module test_dir_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd3;
    logic [1:0]  req_src = '0;
    logic [2:0]  req_blk = '0;
    logic [15:0] req_data = '0;
    logic        rep_valid, inv_valid, fetch_valid, mem_we;
    logic [1:0]  rep_dst, inv_dst, fetch_dst;
    logic [2:0]  inv_blk, fetch_blk, mem_addr;
    logic [15:0] rep_data, mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] mem [8];
    int          ref_st [8];
    logic [3:0]  ref_pres [8];
    int          ref_own [8];
    logic [15:0] exp_mem [8];

    always #4 clk = ~clk;

    dir_ctrl i_dir_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
        .rep_valid(rep_valid), .rep_dst(rep_dst), .rep_data(rep_data),
        .inv_valid(inv_valid), .inv_dst(inv_dst), .inv_blk(inv_blk),
        .fetch_valid(fetch_valid), .fetch_dst(fetch_dst), .fetch_blk(fetch_blk),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // backing memory model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) mem[i] <= 16'hA000 + 16'(i * 17);
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end
    end
    assign mem_rdata = mem[mem_addr];

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic check_reply(input string tag, input int src, input int blk);
        chk(rep_valid === 1'b1, tag, "reply valid", int'(rep_valid), 1);
        chk(rep_dst == 2'(src), tag, "reply dst", int'(rep_dst), src);
        chk(rep_data == exp_mem[blk], tag, "reply data", int'(rep_data), int'(exp_mem[blk]));
        chk(!req_ready && !inv_valid && !fetch_valid, "R10", "busy during reply",
            int'({req_ready, inv_valid, fetch_valid}), 0);
    endtask

    // one message from a cache; kinds: 0 read miss, 1 write miss, 2 write back
    task automatic op(input int kind, input int src, input int blk, input logic [15:0] data,
                      input logic [15:0] wbdata);
        logic [3:0] mask;
        int own;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(kind); req_src = 2'(src); req_blk = 3'(blk); req_data = data;
        #0.5;
        chk(req_ready === 1'b1, "R10", "ready in idle", int'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_kind = 2'd3;
        if (kind == 2) begin
            if (ref_st[blk] == 2 && ref_own[blk] == src) begin
                exp_mem[blk] = data; ref_st[blk] = 0; ref_pres[blk] = 4'b0;
                chk(!rep_valid && !inv_valid && !fetch_valid, "R7", "owner wb quiet",
                    int'({rep_valid, inv_valid, fetch_valid}), 0);
            end else begin
                chk(!rep_valid && !inv_valid && !fetch_valid, "R8", "stray wb quiet",
                    int'({rep_valid, inv_valid, fetch_valid}), 0);
            end
        end else if (ref_st[blk] == 2) begin
            own = ref_own[blk];
            chk(fetch_valid === 1'b1 && fetch_dst == 2'(own) && fetch_blk == 3'(blk),
                (kind == 0) ? "R5" : "R6", "fetch to owner", int'(fetch_dst), own);
            chk(!rep_valid && !inv_valid, "R11", "fetch alone", int'({rep_valid, inv_valid}), 0);
            @(negedge clk);
            chk(!fetch_valid, "R11", "fetch one cycle", int'(fetch_valid), 0);
            req_valid = 1'b1; req_kind = 2'd0; req_src = 2'((own + 1) % 4); req_blk = 3'(blk);
            #0.5;
            chk(!req_ready, "R9", "read miss stalled", int'(req_ready), 0);
            req_kind = 2'd2;
            #0.5;
            chk(!req_ready, "R9", "non-owner wb stalled", int'(req_ready), 0);
            req_src = 2'(own); req_blk = 3'((blk + 1) % 8);
            #0.5;
            chk(!req_ready, "R9", "wrong block wb stalled", int'(req_ready), 0);
            req_blk = 3'(blk); req_data = wbdata;
            #0.5;
            chk(req_ready === 1'b1, "R9", "owner wb accepted", int'(req_ready), 1);
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0; req_kind = 2'd3;
            exp_mem[blk] = wbdata;
            if (kind == 0) begin
                ref_st[blk] = 1; ref_pres[blk] = (4'b1 << own) | (4'b1 << src);
                check_reply("R5", src, blk);
            end else begin
                ref_st[blk] = 2; ref_pres[blk] = 4'b1 << src; ref_own[blk] = src;
                check_reply("R6", src, blk);
            end
        end else if (kind == 1 && ref_st[blk] == 1) begin
            mask = ref_pres[blk] & ~(4'b1 << src);
            for (int i = 0; i < 4; i++) begin
                if (mask[i]) begin
                    chk(inv_valid === 1'b1 && inv_dst == 2'(i) && inv_blk == 3'(blk),
                        "R4", "invalidate target", int'(inv_dst), i);
                    @(negedge clk);
                end
            end
            ref_st[blk] = 2; ref_pres[blk] = 4'b1 << src; ref_own[blk] = src;
            check_reply("R4", src, blk);
        end else if (kind == 1) begin
            ref_st[blk] = 2; ref_pres[blk] = 4'b1 << src; ref_own[blk] = src;
            check_reply("R3", src, blk);
        end else begin
            ref_st[blk] = 1; ref_pres[blk] = ref_pres[blk] | (4'b1 << src);
            check_reply("R2", src, blk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
        end
    end

    initial begin
        logic [31:0] seed;
        int kind, src, blk;
        for (int i = 0; i < 8; i++) begin
            ref_st[i] = 0; ref_pres[i] = 4'b0; ref_own[i] = 0;
            exp_mem[i] = 16'hA000 + 16'(i * 17);
        end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(!rep_valid && !inv_valid && !fetch_valid, "R1", "outputs idle after reset",
            int'({rep_valid, inv_valid, fetch_valid}), 0);

        // directed scenarios on block 0
        op(0, 1, 0, 16'h0, 16'h0);          // R1 uncached read, R2
        op(0, 3, 0, 16'h0, 16'h0);          // R2 shared read
        op(1, 3, 0, 16'h0, 16'h0);          // R4 requester bit skipped
        op(0, 0, 0, 16'h0, 16'h1111);       // R5
        op(1, 2, 0, 16'h0, 16'h0);          // R4 two targets ascending
        op(1, 1, 0, 16'h0, 16'h2222);       // R6
        op(2, 3, 0, 16'hDEAD, 16'h0);       // R8 non-owner write back
        op(0, 0, 0, 16'h0, 16'h3333);       // R8 proof: still fetches owner 1
        op(2, 0, 0, 16'hBEEF, 16'h0);       // R8 write back to shared block
        op(0, 2, 0, 16'h0, 16'h0);          // R8 memory unchanged
        // block 1: write, owner write back, write again
        op(1, 2, 1, 16'h0, 16'h0);          // R3
        op(2, 2, 1, 16'h4444, 16'h0);       // R7
        op(1, 0, 1, 16'h0, 16'h0);          // R7 proof: uncached, data kept
        op(0, 0, 2, 16'h0, 16'h0);          // R4 sole sharer writes: no invalidate
        op(1, 0, 2, 16'h0, 16'h0);

        // pseudo-random sweep over all blocks, caches and kinds
        seed = 32'h1234_5678;
        for (int step = 0; step < 600; step++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            kind = int'(seed[31:28]) % 3;
            src  = int'(seed[27:26]);
            blk  = int'(seed[25:23]);
            if (kind == 2 && seed[22] && ref_st[blk] == 2) src = ref_own[blk];
            op(kind, src, blk, seed[15:0], 16'h5000 + 16'(step));
        end

        done = 1'b1;
        summary();
    end

endmodule